// File: doc/BRIEF.md
# In-System Serial Programming Target

This block sits inside a device and lets an external programmer load and inspect on-chip storage over a three-wire synchronous serial link while the device is held in reset. The programmer drives a serial clock and a data-in line. The block returns data on a data-out line. Every command is a fixed 32-bit frame, sent as four bytes, most significant bit first. Before any storage command takes effect, the programmer must open the session with an enable command. While the enable command is shifted in, the programmer can confirm bit alignment by watching its own second byte come back one byte later.

The serial clock and data lines run asynchronously to the system clock. They pass through a synchroniser, and both clock edges are detected in the system clock domain. A control section counts bits and bytes, keeps the three leading bytes of the frame, and decodes the command. It drives a datapath through one packed strobe bundle. The datapath holds two small byte arrays: a program store, whose cells can only clear bits, and a data store, which takes a byte write in place. The datapath also holds the output shift register. After each write or erase, a busy window runs for a fixed number of system cycles. A poll command reports that window.

Top module: `isp_target`

## Requirements
- R1: A frame is 32 bits, sampled from `mosi` on rising `sck`, most significant bit first. The bit counter wraps after 32 bits, so frames can follow one another with no gap.
- R2: `miso` changes only after a falling `sck`. Each byte is sent most significant bit first. The byte sent during frame byte n+1 is the byte received as byte n. For example, in an enable frame the value 0x53 comes back while the third byte is shifted in.
- R3: The enable command is 0xAC 0x53 xx xx. Until one has been received, every other command has no effect on storage, and the fourth returned byte is the echo of the third byte sent.
- R4: Chip erase (0xAC 0x80 xx xx) sets every byte of both arrays to 0xFF.
- R5: A program write (0x40 hi lo data) replaces the addressed program byte with old AND data. A program cell is never set back to 1 without an erase.
- R6: A data-store write (0xC0 hi lo data) replaces the addressed byte with data, with no prior erase needed.
- R7: A program read (0x20 hi lo xx) or data-store read (0xA0 hi lo xx) returns the addressed byte as the fourth returned byte. The address is {hi,lo} modulo the array depth.
- R8: An accepted write or erase starts a busy window of BUSY_CYCLES system clocks. A poll (0xF0 xx xx xx) returns the busy flag in bit 0 of the fourth returned byte, with bits 7..1 at zero. Writes and erases that complete while the window is open are ignored.
- R9: While `holdInReset` is low, the bit counter and the enable state are cleared and `miso` is driven 0. A partial frame is therefore discarded.
- R10: Each high and low phase of `sck` must last more than SCK_MIN_CYCLES system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low system reset; fills both arrays with 0xFF |
| holdInReset | input | 1 | High while the device is held in reset and the serial link is active |
| sck | input | 1 | Serial clock from the programmer |
| mosi | input | 1 | Serial data from the programmer |
| miso | output | 1 | Serial data to the programmer |

## Verification
The assertions assume that the programmer holds each `sck` level longer than SCK_MIN_CYCLES system clocks. They also assume that `mosi` changes only while `sck` is low, so that a sampled bit is settled when the rising edge is seen. The bench keeps every phase between 5 and 8 system clocks and sets `mosi` at the start of each low phase. It samples `miso` at the end of that low phase, which is later than the three-cycle path from a falling edge to `miso`. After each accepted write it waits longer than the busy window, except in the directed cases that probe that window on purpose.

// File: rtl/isp_pkg.sv
package isp_pkg;

  localparam logic [7:0] OP_ENTRY   = 8'hAC;
  localparam logic [7:0] KEY_ENABLE = 8'h53;
  localparam logic [7:0] KEY_ERASE  = 8'h80;
  localparam logic [7:0] OP_PROG_WR = 8'h40;
  localparam logic [7:0] OP_PROG_RD = 8'h20;
  localparam logic [7:0] OP_EE_WR   = 8'hC0;
  localparam logic [7:0] OP_EE_RD   = 8'hA0;
  localparam logic [7:0] OP_POLL    = 8'hF0;

  typedef enum logic [1:0] {
    TX_ECHO,
    TX_PROG,
    TX_EE,
    TX_BUSY
  } txSel_e;

  typedef struct packed {
    logic        clrTx;
    logic        loadTx;
    logic        shiftTx;
    txSel_e      txSel;
    logic        wrProg;
    logic        wrEe;
    logic        eraseAll;
    logic        busyBit;
    logic [15:0] addr;
    logic [7:0]  data;
  } dpCmd_t;

endpackage

// File: rtl/isp_sync.sv
module isp_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          stageQ[s] <= '0;
        end else if (s == 0) begin
          stageQ[s] <= asyncIn;
        end else begin
          stageQ[s] <= stageQ[(s == 0) ? 0 : s - 1];
        end
      end
    end
  endgenerate

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/isp_ctrl.sv
module isp_ctrl
  import isp_pkg::*;
#(
  parameter int SCK_MIN_CYCLES = 3,
  parameter int BUSY_CYCLES    = 200
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   holdS,
  input  logic   sckS,
  input  logic   mosiS,
  output dpCmd_t cmd
);

  localparam int PH_SAT = SCK_MIN_CYCLES + 1;
  localparam int PH_W   = $clog2(PH_SAT + 1);
  localparam int BW     = $clog2(BUSY_CYCLES + 1);

  logic            sckPrev;
  logic            sckRise;
  logic            sckFall;
  logic [4:0]      bitCnt;
  logic [1:0]      byteIdx;
  logic [7:0]      rxShift;
  logic [7:0]      rxNext;
  logic [7:0]      opByte;
  logic [7:0]      keyByte;
  logic [7:0]      loByte;
  logic            enabled;
  logic [BW-1:0]   busyCnt;
  logic            busy;
  logic            byteDone;
  logic            frameDone;
  logic            startOp;
  logic [PH_W-1:0] phaseCnt;

  assign sckRise   = sckS & ~sckPrev;
  assign sckFall   = ~sckS & sckPrev;
  assign byteIdx   = bitCnt[4:3];
  assign rxNext    = {rxShift[6:0], mosiS};
  assign byteDone  = holdS && sckRise && (bitCnt[2:0] == 3'd7);
  assign frameDone = byteDone && (byteIdx == 2'd3);
  assign busy      = (busyCnt != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPrev <= 1'b0;
    end else begin
      sckPrev <= sckS;
    end
  end

  // frame assembly
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      rxShift <= '0;
      opByte  <= '0;
      keyByte <= '0;
      loByte  <= '0;
      enabled <= 1'b0;
    end else if (!holdS) begin
      bitCnt  <= '0;
      rxShift <= '0;
      enabled <= 1'b0;
    end else if (sckRise) begin
      bitCnt  <= bitCnt + 5'd1;
      rxShift <= rxNext;
      if (bitCnt[2:0] == 3'd7) begin
        case (byteIdx)
          2'd0:    opByte  <= rxNext;
          2'd1:    keyByte <= rxNext;
          2'd2:    loByte  <= rxNext;
          default: ;
        endcase
      end
      if (frameDone && opByte == OP_ENTRY && keyByte == KEY_ENABLE) begin
        enabled <= 1'b1;
      end
    end
  end

  // busy window of the self-timed operation
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyCnt <= '0;
    end else if (startOp) begin
      busyCnt <= BW'(BUSY_CYCLES);
    end else if (busy) begin
      busyCnt <= busyCnt - 1'b1;
    end
  end

  // phase length monitor for the input assumption on sck
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= PH_W'(PH_SAT);
    end else if (sckS != sckPrev) begin
      phaseCnt <= PH_W'(1);
    end else if (phaseCnt < PH_W'(PH_SAT)) begin
      phaseCnt <= phaseCnt + 1'b1;
    end
  end

  // decode into datapath strobes
  always_comb begin
    cmd         = '0;
    cmd.clrTx   = !holdS;
    cmd.shiftTx = holdS && sckFall;
    cmd.loadTx  = byteDone;
    cmd.busyBit = busy;
    cmd.txSel   = TX_ECHO;
    cmd.data    = rxNext;
    cmd.addr    = (byteIdx == 2'd2) ? {keyByte, rxNext} : {keyByte, loByte};
    if (byteIdx == 2'd2 && enabled) begin
      case (opByte)
        OP_PROG_RD: cmd.txSel = TX_PROG;
        OP_EE_RD:   cmd.txSel = TX_EE;
        OP_POLL:    cmd.txSel = TX_BUSY;
        default:    cmd.txSel = TX_ECHO;
      endcase
    end
    if (frameDone && enabled && !busy) begin
      case (opByte)
        OP_PROG_WR: cmd.wrProg   = 1'b1;
        OP_EE_WR:   cmd.wrEe     = 1'b1;
        OP_ENTRY:   cmd.eraseAll = (keyByte == KEY_ERASE);
        default:    ;
      endcase
    end
  end

  assign startOp = cmd.wrProg | cmd.wrEe | cmd.eraseAll;

  assert_sck_phase_R10: assert property (@(posedge clk) disable iff (!rstN)
    (sckS != sckPrev) |-> (phaseCnt > PH_W'(SCK_MIN_CYCLES)));

  assert_enable_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    !holdS |=> (!enabled && bitCnt == 5'd0));

  assert_busy_after_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    startOp |=> busy);

endmodule

// File: rtl/isp_dp.sv
module isp_dp
  import isp_pkg::*;
#(
  parameter int PROG_DEPTH = 64,
  parameter int EE_DEPTH   = 32
) (
  input  logic   clk,
  input  logic   rstN,
  input  dpCmd_t cmd,
  output logic   miso
);

  localparam int PA_W = $clog2(PROG_DEPTH);
  localparam int EA_W = $clog2(EE_DEPTH);

  logic [7:0]      progMem [PROG_DEPTH];
  logic [7:0]      eeMem   [EE_DEPTH];
  logic [PA_W-1:0] pIdx;
  logic [EA_W-1:0] eIdx;
  logic [7:0]      txByte;
  logic [7:0]      txShift;
  logic            misoQ;

  assign pIdx = PA_W'(cmd.addr % 16'(PROG_DEPTH));
  assign eIdx = EA_W'(cmd.addr % 16'(EE_DEPTH));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < PROG_DEPTH; i++) progMem[i] <= 8'hFF;
    end else if (cmd.eraseAll) begin
      for (int i = 0; i < PROG_DEPTH; i++) progMem[i] <= 8'hFF;
    end else if (cmd.wrProg) begin
      progMem[pIdx] <= progMem[pIdx] & cmd.data;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < EE_DEPTH; i++) eeMem[i] <= 8'hFF;
    end else if (cmd.eraseAll) begin
      for (int i = 0; i < EE_DEPTH; i++) eeMem[i] <= 8'hFF;
    end else if (cmd.wrEe) begin
      eeMem[eIdx] <= cmd.data;
    end
  end

  always_comb begin
    case (cmd.txSel)
      TX_PROG: txByte = progMem[pIdx];
      TX_EE:   txByte = eeMem[eIdx];
      TX_BUSY: txByte = {7'd0, cmd.busyBit};
      default: txByte = cmd.data;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      misoQ   <= 1'b0;
    end else if (cmd.clrTx) begin
      txShift <= '0;
      misoQ   <= 1'b0;
    end else if (cmd.loadTx) begin
      txShift <= txByte;
    end else if (cmd.shiftTx) begin
      misoQ   <= txShift[7];
      txShift <= {txShift[6:0], 1'b0};
    end
  end

  assign miso = misoQ;

  assert_miso_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.shiftTx && !cmd.clrTx) |=> $stable(misoQ));

  assert_erase_fill_R4: assert property (@(posedge clk) disable iff (!rstN)
    cmd.eraseAll |=> (progMem[0] == 8'hFF && progMem[PROG_DEPTH-1] == 8'hFF
                      && eeMem[0] == 8'hFF && eeMem[EE_DEPTH-1] == 8'hFF));

  assert_ee_replace_R6: assert property (@(posedge clk) disable iff (!rstN)
    cmd.wrEe |=> (eeMem[$past(eIdx)] == $past(cmd.data)));

  assert_prog_and_R5: assert property (@(posedge clk) disable iff (!rstN)
    cmd.wrProg |=> ((progMem[$past(pIdx)] & ~$past(progMem[pIdx])) == 8'h00));

endmodule

// File: rtl/isp_target.sv
module isp_target #(
  parameter int PROG_DEPTH     = 64,
  parameter int EE_DEPTH       = 32,
  parameter int SCK_MIN_CYCLES = 3,
  parameter int BUSY_CYCLES    = 200
) (
  input  logic clk,
  input  logic rstN,
  input  logic holdInReset,
  input  logic sck,
  input  logic mosi,
  output logic miso
);

  isp_pkg::dpCmd_t cmd;
  logic [2:0]      syncVec;

  isp_sync #(.WIDTH(3), .STAGES(2)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({holdInReset, sck, mosi}),
    .syncOut (syncVec)
  );

  isp_ctrl #(
    .SCK_MIN_CYCLES (SCK_MIN_CYCLES),
    .BUSY_CYCLES    (BUSY_CYCLES)
  ) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .holdS (syncVec[2]),
    .sckS  (syncVec[1]),
    .mosiS (syncVec[0]),
    .cmd   (cmd)
  );

  isp_dp #(
    .PROG_DEPTH (PROG_DEPTH),
    .EE_DEPTH   (EE_DEPTH)
  ) u_dp (
    .clk  (clk),
    .rstN (rstN),
    .cmd  (cmd),
    .miso (miso)
  );

endmodule

// File: tb/isp_target_test.sv
module isp_target_test;

  localparam int PD   = 64;
  localparam int ED   = 32;
  localparam int BUSY = 1500;
  localparam int IDLE = 1600;
  localparam int WD_LIMIT = 190000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic holdInReset = 1'b0;
  logic sck = 1'b0;
  logic mosi = 1'b0;
  logic miso;

  int vecs = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  logic [7:0] mProg [PD];
  logic [7:0] mEe   [ED];
  bit mEn = 0;

  isp_target #(
    .PROG_DEPTH(PD), .EE_DEPTH(ED), .SCK_MIN_CYCLES(3), .BUSY_CYCLES(BUSY)
  ) uut (
    .clk(clk), .rstN(rstN), .holdInReset(holdInReset),
    .sck(sck), .mosi(mosi), .miso(miso)
  );

  always #4ns clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    vecs++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitPhase();
    idle(5 + int'($urandom_range(0, 3)));
  endtask

  task automatic xferBits(input logic [31:0] word, input int nBits, output logic [31:0] resp);
    resp = '0;
    for (int i = 31; i > 31 - nBits; i--) begin
      mosi = word[i];
      waitPhase();
      resp[i] = miso;
      sck = 1'b1;
      waitPhase();
      sck = 1'b0;
    end
  endtask

  function automatic logic [7:0] expFourth(input logic [7:0] a, input logic [7:0] c, input bit busyNow);
    if (!mEn) return c;
    case (a)
      8'h20:   return mProg[c[5:0]];
      8'hA0:   return mEe[c[4:0]];
      8'hF0:   return {7'd0, busyNow};
      default: return c;
    endcase
  endfunction

  // runs one frame against the model; returns whether a write was accepted
  task automatic runFrame(input logic [7:0] a, b, c, d, input bit busyNow,
                          input string tag, output bit wrote);
    logic [31:0] r;
    logic [7:0]  e3;
    e3 = expFourth(a, c, busyNow);
    xferBits({a, b, c, d}, 32, r);
    check({tag, " R2 echo byte1"}, r[23:16], a);
    check({tag, " R2 echo byte2"}, r[15:8], b);
    check({tag, " R7 fourth byte"}, r[7:0], e3);
    wrote = 0;
    if (mEn && !busyNow) begin
      if (a == 8'h40) begin mProg[c[5:0]] = mProg[c[5:0]] & d; wrote = 1; end
      if (a == 8'hC0) begin mEe[c[4:0]] = d; wrote = 1; end
      if (a == 8'hAC && b == 8'h80) begin
        for (int i = 0; i < PD; i++) mProg[i] = 8'hFF;
        for (int i = 0; i < ED; i++) mEe[i] = 8'hFF;
        wrote = 1;
      end
    end
    if (a == 8'hAC && b == 8'h53) mEn = 1;
  endtask

  task automatic frame(input logic [7:0] a, b, c, d, input string tag);
    bit w;
    runFrame(a, b, c, d, 1'b0, tag, w);
    if (w) idle(IDLE);
  endtask

  initial begin : watchdog
    wait (cyc >= WD_LIMIT);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1 actual=%0d cycles expected<%0d", cyc, WD_LIMIT);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] r;
    bit w;
    int seedDummy;
    seedDummy = $urandom(32'h15b7);
    for (int i = 0; i < PD; i++) mProg[i] = 8'hFF;
    for (int i = 0; i < ED; i++) mEe[i] = 8'hFF;

    idle(5);
    check("R9 reset miso", {7'd0, miso}, 8'h00);
    rstN = 1'b1;
    idle(5);
    holdInReset = 1'b1;
    idle(10);

    // R3: commands before enable have no effect, read returns echo
    frame(8'hC0, 8'h00, 8'h05, 8'h12, "R3 write before enable");
    frame(8'hAC, 8'h54, 8'h00, 8'h00, "R3 bad enable key");
    frame(8'hA0, 8'h00, 8'h05, 8'h00, "R3 read before enable");

    // R2/R3: proper enable, second byte comes back during third
    frame(8'hAC, 8'h53, 8'h00, 8'h00, "R2 enable");
    frame(8'hA0, 8'h00, 8'h05, 8'h00, "R3 read after enable");

    // R6: data-store write replaces without erase
    frame(8'hC0, 8'h00, 8'h05, 8'h5A, "R6 ee write");
    frame(8'hC0, 8'h00, 8'h05, 8'hA5, "R6 ee overwrite");
    frame(8'hA0, 8'h00, 8'h05, 8'h00, "R6 ee readback");

    // R5: program write only clears bits
    frame(8'h40, 8'h00, 8'h09, 8'hF0, "R5 prog write");
    frame(8'h40, 8'h00, 8'h09, 8'h3C, "R5 prog and");
    frame(8'h20, 8'h00, 8'h09, 8'h00, "R5 prog readback");

    // R7: address wraps modulo depth
    frame(8'h20, 8'h00, 8'h49, 8'h00, "R7 prog wrap");
    frame(8'hA0, 8'h00, 8'h25, 8'h00, "R7 ee wrap");

    // R8: busy window, poll, and ignored write while busy
    runFrame(8'hC0, 8'h00, 8'h03, 8'h11, 1'b0, "R8 first write", w);
    runFrame(8'hF0, 8'h00, 8'h00, 8'h00, 1'b1, "R8 poll busy", w);
    runFrame(8'hC0, 8'h00, 8'h03, 8'h22, 1'b1, "R8 write while busy", w);
    idle(IDLE);
    frame(8'hF0, 8'h00, 8'h00, 8'h00, "R8 poll idle");
    frame(8'hA0, 8'h00, 8'h03, 8'h00, "R8 ignored write readback");

    // R4: chip erase
    frame(8'hAC, 8'h80, 8'h00, 8'h00, "R4 erase");
    frame(8'h20, 8'h00, 8'h09, 8'h00, "R4 prog erased");
    frame(8'hA0, 8'h00, 8'h05, 8'h00, "R4 ee erased");

    // R9: partial frame discarded, enable cleared on release
    xferBits(32'hA0000000, 5, r);
    holdInReset = 1'b0;
    idle(12);
    check("R9 miso low when released", {7'd0, miso}, 8'h00);
    mEn = 0;
    holdInReset = 1'b1;
    idle(10);
    frame(8'hC0, 8'h00, 8'h07, 8'h00, "R9 write after release");
    frame(8'hA0, 8'h00, 8'h07, 8'h77, "R9 read after release");
    frame(8'hAC, 8'h53, 8'h99, 8'h00, "R9 re-enable");
    frame(8'hA0, 8'h00, 8'h07, 8'h00, "R9 data unchanged");

    // R1: random back-to-back frames
    for (int n = 0; n < 40; n++) begin
      logic [7:0] a, c, d;
      int pick;
      pick = int'($urandom_range(0, 9));
      c = 8'($urandom);
      d = 8'($urandom);
      case (pick)
        0, 1:    a = 8'h40;
        2, 3:    a = 8'hC0;
        4, 5:    a = 8'h20;
        6, 7:    a = 8'hA0;
        8:       a = 8'hF0;
        default: a = 8'h5D;
      endcase
      frame(a, 8'h00, c, d, "R1 random");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

endmodule